// File: doc/BRIEF.md
# LRU Arbiter with Extended Grants

This block decides which of four request groups, numbered 2 to 5, may use a shared memory scheduler next. Among the groups whose requests are visible it normally picks the one served least recently. A single group can be promoted so that it beats every other group whenever it asks. Once a group wins, it may keep the grant for one, two or three back-to-back services before the arbiter looks again.

Each group can also be told to hold its request back until a whole burst sits in its buffer. Until then its request stays invisible to arbitration. The scheduler signals the end of each service with a one-cycle done pulse. The arbiter holds a one-hot grant that changes only on such a pulse, or when no grant is active. A 32-bit configuration register with a write strobe and a read-back sets the override, the service counts and the burst holds.

Vector bit i of `req`, `burst_rdy` and `grant` belongs to group i+2. The register layout, with group 2 at the lowest bit of each field, is: burst hold bits 29:26, service counts in 2-bit fields at 19:12 (group 2 at 13:12), and top-priority bits at 5:2.

Top module: `lru_grant_arbiter`

## Requirements
- R1: After reset `grant` is 0, `cfg_rdata` reads 0x00055000 (every service count 1, no holds, no override), and the recency order from oldest to newest is group 2, 3, 4, 5.
- R2: A write with `cfg_we` high is visible on `cfg_rdata` after the next clock edge as `cfg_wdata & 0x3C0FF03C`; reserved bits read back as 0 and have no effect on arbitration.
- R3: When `grant` is 0 and at least one group is eligible, `grant` becomes one-hot after the next edge on the eligible group that was served least recently; a group that did not request is never newly granted.
- R4: `grant` is never more than one-hot, and bit i stands for group i+2.
- R5: When top-priority bits are set, only the lowest-numbered set group holds the override; if that group is eligible it wins arbitration, otherwise the winner follows recency order.
- R6: A group whose service-count field holds n (1 to 3) keeps the grant through n `svc_done` pulses and loses it on the n-th; a field of 0 acts as 1.
- R7: If the granted group is not eligible at a `svc_done` pulse, the grant is released on that pulse whatever services remain.
- R8: While a grant is active and `svc_done` is low, `grant` does not change; a `svc_done` pulse while no grant is active has no effect.
- R9: A group that gives up the grant becomes the most recently served group.
- R10: A group with its burst-hold bit at 0 is eligible whenever `req` is high; with the bit at 1 it is eligible only while both `req` and `burst_rdy` are high.
- R11: After a release, `grant` is 0 for one cycle before the next winner is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration register read-back |
| req | input | 4 | Per-group request, bit i for group i+2 |
| burst_rdy | input | 4 | Per-group flag that a whole burst is buffered |
| svc_done | input | 1 | One-cycle pulse at the end of a service |
| grant | output | 4 | One-hot grant, bit i for group i+2 |

## Verification
The bench targets the override that names two groups: a design that honoured the highest set bit, or let a second set bit take over when the lowest one is idle, would grant the wrong group. It drives service counts of 0 and 3 and a request dropped in mid-run, where an off-by-one counter would keep or release the grant one pulse too early or late. Burst holds are driven with `burst_rdy` low and then high, so that a hold ignored or applied to the wrong group shows up as an early grant. A long random run against a behavioural recency queue exposes any slip in moving the released group to the newest slot, which would make later winners drift from the expected order.

// File: rtl/arb_pkg.sv
package arb_pkg;

    localparam int NUM_GRP  = 4;
    localparam int CNT_W    = 2;
    localparam int CFG_W    = 32;
    localparam int ID_W     = $clog2(NUM_GRP);
    localparam int GATE_LSB = 26;
    localparam int CNT_LSB  = 12;
    localparam int PRIO_LSB = 2;

    localparam logic [CFG_W-1:0] GRP_ONES = CFG_W'((1 << NUM_GRP) - 1);
    localparam logic [CFG_W-1:0] CNT_ONES = CFG_W'((1 << (NUM_GRP * CNT_W)) - 1);
    localparam logic [CFG_W-1:0] CFG_MASK = (GRP_ONES << GATE_LSB)
                                          | (CNT_ONES << CNT_LSB)
                                          | (GRP_ONES << PRIO_LSB);

    typedef logic [NUM_GRP-1:0] grp_vec_t;
    typedef logic [ID_W-1:0]    grp_id_t;
    typedef logic [CNT_W-1:0]   cnt_t;

    // Reset word: every service-count field set to one service
    function automatic logic [CFG_W-1:0] cfg_reset_word();
        logic [CFG_W-1:0] w;
        w = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            w[CNT_LSB + g*CNT_W +: CNT_W] = cnt_t'(1);
        end
        return w;
    endfunction

    localparam logic [CFG_W-1:0] CFG_RST = cfg_reset_word();

    typedef struct packed {
        logic [CFG_W-1:0]          cfg;
        grp_vec_t                  grant;
        cnt_t                      left;
        grp_id_t [NUM_GRP-1:0]     order;   // index 0 = least recently served
    } arb_state_t;

endpackage

// File: rtl/arb_cfg_decode.sv
module arb_cfg_decode
    import arb_pkg::*;
#(
    parameter int N  = NUM_GRP,
    parameter int CW = CNT_W
) (
    input  logic [CFG_W-1:0]       cfg_word,
    output logic [N-1:0]           gate_en,
    output logic [N-1:0]           prio_en,
    output logic [N-1:0][CW-1:0]   svc_cnt
);

    for (genvar g = 0; g < N; g++) begin : g_field
        logic [CW-1:0] raw_cnt;
        assign gate_en[g] = cfg_word[GATE_LSB + g];
        assign prio_en[g] = cfg_word[PRIO_LSB + g];
        assign raw_cnt    = cfg_word[CNT_LSB + g*CW +: CW];
        // a zero count behaves as a single service
        assign svc_cnt[g] = (raw_cnt == '0) ? CW'(1) : raw_cnt;
    end

endmodule

// File: rtl/arb_req_gate.sv
module arb_req_gate
    import arb_pkg::*;
#(
    parameter int N = NUM_GRP
) (
    input  logic [N-1:0] req,
    input  logic [N-1:0] burst_rdy,
    input  logic [N-1:0] gate_en,
    output logic [N-1:0] elig
);

    for (genvar g = 0; g < N; g++) begin : g_gate
        assign elig[g] = req[g] & (~gate_en[g] | burst_rdy[g]);
    end

endmodule

// File: rtl/arb_pick.sv
module arb_pick
    import arb_pkg::*;
#(
    parameter int N  = NUM_GRP,
    parameter int IW = ID_W
) (
    input  logic [N-1:0]           elig,
    input  logic [N-1:0]           prio_en,
    input  logic [N-1:0][IW-1:0]   order,
    output logic                   win_vld,
    output logic [IW-1:0]          win_id
);

    logic          hp_found;
    logic [IW-1:0] hp_id;

    // lowest-numbered set priority bit holds the override
    always_comb begin
        hp_found = 1'b0;
        hp_id    = '0;
        for (int i = 0; i < N; i++) begin
            if (!hp_found && prio_en[i]) begin
                hp_found = 1'b1;
                hp_id    = IW'(i);
            end
        end
    end

    always_comb begin
        win_vld = 1'b0;
        win_id  = '0;
        if (hp_found && elig[hp_id]) begin
            win_vld = 1'b1;
            win_id  = hp_id;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (!win_vld && elig[order[i]]) begin
                    win_vld = 1'b1;
                    win_id  = order[i];
                end
            end
        end
    end

endmodule

// File: rtl/lru_grant_arbiter.sv
module lru_grant_arbiter
    import arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic [NUM_GRP-1:0] req,
    input  logic [NUM_GRP-1:0] burst_rdy,
    input  logic             svc_done,
    output logic [NUM_GRP-1:0] grant
);

    arb_state_t st_d, st_q;

    grp_vec_t               gate_en;
    grp_vec_t               prio_en;
    cnt_t [NUM_GRP-1:0]     svc_cnt;
    grp_vec_t               elig;
    logic                   win_vld;
    grp_id_t                win_id;
    grp_id_t                owner_id;
    grp_id_t                owner_pos;
    grp_id_t [NUM_GRP-1:0]  order_mru;
    logic                   owner_elig;

    arb_cfg_decode #(.N(NUM_GRP), .CW(CNT_W)) i_decode (
        .cfg_word (st_q.cfg),
        .gate_en  (gate_en),
        .prio_en  (prio_en),
        .svc_cnt  (svc_cnt)
    );

    arb_req_gate #(.N(NUM_GRP)) i_gate (
        .req       (req),
        .burst_rdy (burst_rdy),
        .gate_en   (gate_en),
        .elig      (elig)
    );

    arb_pick #(.N(NUM_GRP), .IW(ID_W)) i_pick (
        .elig    (elig),
        .prio_en (prio_en),
        .order   (st_q.order),
        .win_vld (win_vld),
        .win_id  (win_id)
    );

    // index of the current owner and its slot in the recency list
    always_comb begin
        owner_id  = '0;
        owner_pos = '0;
        for (int i = 0; i < NUM_GRP; i++) begin
            if (st_q.grant[i]) begin
                owner_id = grp_id_t'(i);
            end
        end
        for (int i = 0; i < NUM_GRP; i++) begin
            if (st_q.order[i] == owner_id) begin
                owner_pos = grp_id_t'(i);
            end
        end
    end

    // recency list with the owner moved to the newest slot
    always_comb begin
        for (int i = 0; i < NUM_GRP - 1; i++) begin
            order_mru[i] = (grp_id_t'(i) >= owner_pos) ? st_q.order[i+1] : st_q.order[i];
        end
        order_mru[NUM_GRP-1] = owner_id;
    end

    assign owner_elig = |(st_q.grant & elig);

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            st_d.cfg = cfg_wdata & CFG_MASK;
        end
        if (st_q.grant == '0) begin
            if (win_vld) begin
                st_d.grant = grp_vec_t'(1) << win_id;
                st_d.left  = svc_cnt[win_id];
            end
        end else if (svc_done) begin
            if ((st_q.left <= cnt_t'(1)) || !owner_elig) begin
                st_d.grant = '0;
                st_d.left  = '0;
                st_d.order = order_mru;
            end else begin
                st_d.left  = st_q.left - cnt_t'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cfg   <= CFG_RST;
            st_q.grant <= '0;
            st_q.left  <= '0;
            for (int i = 0; i < NUM_GRP; i++) begin
                st_q.order[i] <= grp_id_t'(i);
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_rdata = st_q.cfg;
    assign grant     = st_q.grant;

endmodule

// File: rtl/arb_checker.sv
module arb_checker
    import arb_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [CFG_W-1:0]   cfg_rdata,
    input logic [NUM_GRP-1:0] req,
    input logic               svc_done,
    input logic [NUM_GRP-1:0] grant
);

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R4

    AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0 && !svc_done) |=> $stable(grant)); // R8

    AST_NEW_GRANT_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0) |=> ((grant & ~$past(req)) == '0)); // R3

    AST_DROP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0 && svc_done && (grant & req) == '0) |=> (grant == '0)); // R7

    AST_RELEASE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0 && svc_done) |=> (grant == '0 || grant == $past(grant))); // R11

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_rdata & ~CFG_MASK) == '0)); // R2

endmodule

bind lru_grant_arbiter arb_checker i_arb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_rdata (cfg_rdata),
    .req       (req),
    .svc_done  (svc_done),
    .grant     (grant)
);

// File: tb/test_lru_grant_arbiter.sv
module test_lru_grant_arbiter;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic [3:0]  req;
    logic [3:0]  burst_rdy;
    logic        svc_done;
    logic [3:0]  grant;

    always #10 clk = ~clk;   // 50 MHz

    lru_grant_arbiter i_lru_grant_arbiter (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .req       (req),
        .burst_rdy (burst_rdy),
        .svc_done  (svc_done),
        .grant     (grant)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_tag = "R1";
    logic  finished = 1'b0;

    // ---------------- behavioural reference model ----------------
    int          lru[$];
    int          owner;
    int          left;
    logic [31:0] mcfg;
    logic [3:0]  exp_grant;
    logic [3:0]  m_el;
    int          m_hp;
    int          m_win;

    always @(posedge clk) begin
        if (!rst_n) begin
            lru   = '{0, 1, 2, 3};
            owner = -1;
            left  = 0;
            mcfg  = 32'h0005_5000;
        end else begin
            for (int i = 0; i < 4; i++) begin
                m_el[i] = req[i] && (!mcfg[26+i] || burst_rdy[i]);
            end
            if (owner < 0) begin
                m_hp  = -1;
                m_win = -1;
                for (int i = 3; i >= 0; i--) begin
                    if (mcfg[2+i]) m_hp = i;
                end
                if (m_hp >= 0 && m_el[m_hp]) begin
                    m_win = m_hp;
                end else begin
                    for (int j = 0; j < lru.size(); j++) begin
                        if (m_win < 0 && m_el[lru[j]]) m_win = lru[j];
                    end
                end
                if (m_win >= 0) begin
                    owner = m_win;
                    left  = int'(mcfg[12 + 2*m_win +: 2]);
                    if (left == 0) left = 1;
                end
            end else if (svc_done) begin
                if (left <= 1 || !m_el[owner]) begin
                    for (int j = 0; j < lru.size(); j++) begin
                        if (lru[j] == owner) begin
                            lru.delete(j);
                            break;
                        end
                    end
                    lru.push_back(owner);
                    owner = -1;
                    left  = 0;
                end else begin
                    left = left - 1;
                end
            end
            if (cfg_we) mcfg = cfg_wdata & 32'h3C0F_F03C;
        end
        exp_grant = (owner < 0) ? 4'b0000 : 4'(1 << owner);
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !finished) begin
            check({cur_tag, " grant"}, {28'b0, grant}, {28'b0, exp_grant});
            check({cur_tag, " cfg"},   cfg_rdata, mcfg);
            check("R4 onehot", {31'b0, ($countones(grant) <= 1)}, 32'd1);
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
        req = '0; burst_rdy = '0; svc_done = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic wr_cfg(logic [31:0] d);
        cfg_we = 1'b1; cfg_wdata = d;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic expect_grant(string tag, logic [3:0] e);
        check(tag, {28'b0, grant}, {28'b0, e});
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        cur_tag = "R1";
        do_reset();
        expect_grant("R1 grant after reset", 4'b0000);
        check("R1 cfg after reset", cfg_rdata, 32'h0005_5000);

        // R2 write masking, reserved bits ignored
        cur_tag = "R2";
        wr_cfg(32'hFFFF_FFFF);
        check("R2 masked write", cfg_rdata, 32'h3C0F_F03C);
        wr_cfg(32'hC3F0_0FC3);
        check("R2 reserved only", cfg_rdata, 32'h0000_0000);
        req = 4'b0100;
        step();
        expect_grant("R2 reserved bits no effect", 4'b0100);
        req = 4'b0000; svc_done = 1'b1;
        step();
        svc_done = 1'b0;
        expect_grant("R2 zero count one service", 4'b0000);

        // R3 LRU pick, R11 gap, R9 most recent
        cur_tag = "R3";
        do_reset();
        req = 4'b1111;
        step();
        expect_grant("R3 oldest group 2 wins", 4'b0001);
        svc_done = 1'b1;
        step();
        svc_done = 1'b0;
        expect_grant("R11 idle cycle after release", 4'b0000);
        step();
        expect_grant("R9 released group moved to newest", 4'b0010);

        // R5 override
        cur_tag = "R5";
        do_reset();
        wr_cfg(32'h0005_5018);
        req = 4'b1111;
        step();
        expect_grant("R5 lowest set priority group 3 wins", 4'b0010);
        svc_done = 1'b1;
        step();
        svc_done = 1'b0;
        expect_grant("R5 release gap", 4'b0000);
        step();
        expect_grant("R5 override beats recency", 4'b0010);
        req = 4'b1101; svc_done = 1'b1;
        step();
        svc_done = 1'b0;
        expect_grant("R5 release", 4'b0000);
        step();
        expect_grant("R5 idle override falls back to recency", 4'b0001);

        // R6 three services
        cur_tag = "R6";
        do_reset();
        wr_cfg(32'h0005_7000);
        req = 4'b0001;
        step();
        expect_grant("R6 granted", 4'b0001);
        svc_done = 1'b1;
        step();
        expect_grant("R6 kept after first done", 4'b0001);
        step();
        expect_grant("R6 kept after second done", 4'b0001);
        step();
        svc_done = 1'b0;
        expect_grant("R6 released on third done", 4'b0000);

        // R7 drop releases early
        cur_tag = "R7";
        do_reset();
        wr_cfg(32'h0007_5000);
        req = 4'b0100;
        step();
        expect_grant("R7 group 4 granted", 4'b0100);
        req = 4'b0000; svc_done = 1'b1;
        step();
        svc_done = 1'b0;
        expect_grant("R7 dropped request releases", 4'b0000);

        // R8 hold and ignored done
        cur_tag = "R8";
        do_reset();
        svc_done = 1'b1;
        step();
        svc_done = 1'b0;
        expect_grant("R8 done without grant ignored", 4'b0000);
        req = 4'b0100;
        step();
        expect_grant("R8 group 4 granted", 4'b0100);
        req = 4'b1111;
        repeat (3) step();
        expect_grant("R8 grant held without done", 4'b0100);

        // R10 burst hold
        cur_tag = "R10";
        do_reset();
        wr_cfg(32'h0405_5000);
        req = 4'b0011; burst_rdy = 4'b0000;
        step();
        expect_grant("R10 held group 2 hidden, group 3 wins", 4'b0010);
        req = 4'b0001; svc_done = 1'b1;
        step();
        svc_done = 1'b0;
        step();
        expect_grant("R10 held group 2 still hidden", 4'b0000);
        burst_rdy = 4'b0001;
        step();
        expect_grant("R10 group 2 granted once burst ready", 4'b0001);

        // random run against the model
        cur_tag = "R3 R5 R6 R7 R9 R10 random";
        do_reset();
        for (int c = 0; c < 6000; c++) begin
            req       = 4'($urandom);
            burst_rdy = 4'($urandom);
            svc_done  = ($urandom % 3) == 0;
            cfg_we    = ($urandom % 40) == 0;
            cfg_wdata = $urandom;
            step();
        end
        cfg_we = 1'b0; svc_done = 1'b0; req = '0;
        step();

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule